// File: doc/BRIEF.md
# Packet Stream Lane Bridge

This block takes a packetized byte-symbol stream with start and end markers and a count of unused symbols in the final word. It turns that stream into a keep-mask stream of the kind used by AXI4-Stream sinks. Both sides use a plain valid/ready handshake with no ready delay: a word moves in any cycle where valid and ready are both high.

The block does four things on the way through:
- It reverses the symbol order when the source puts its first symbol in the high bits, so the first symbol always leaves on the lowest byte lane.
- It turns the unused-symbol count into a per-lane keep mask.
- It encodes a zero-length packet as an all-zero keep mask with last set.
- It carries the channel number and the error code alongside the data, as identifier and user sideband.

A single output register decouples the two sides. A sticky flag reports a start marker that arrives in the middle of a packet.

Top module: `pkt_lane_bridge`

## Requirements
- R1: With HI_FIRST=1, the symbol in the most significant byte of in_data (the first symbol) appears in out_tdata[7:0], and the symbol order is fully reversed across lanes.
- R2: With HI_FIRST=0, out_tdata equals in_data unchanged.
- R3: On a word with in_eop=0, out_tkeep is all ones whatever value in_empty holds.
- R4: On a word with in_eop=1 and in_empty=e < SYMS, out_tkeep has exactly its low SYMS-e bits set.
- R5: On a word with in_eop=1 and in_empty=SYMS (zero-length packet), out_tkeep is all zeros and out_tlast is 1.
- R6: out_tlast equals the word's in_eop. out_tid equals its in_chan. out_tuser equals its in_err.
- R7: A word is taken when in_valid and in_ready are both 1, and it is presented with out_tvalid=1 from the next cycle. in_ready equals (not out_tvalid) or out_tready.
- R8: While out_tvalid=1 and out_tready=0, out_tvalid and every output field hold their values.
- R9: A word taken with in_sop=1 after a word without in_eop in the same packet sets proto_err. proto_err then stays 1 until reset.
- R10: After reset, out_tvalid=0, in_ready=1 and proto_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Bridge can take a word |
| in_data | input | SYM_W*SYMS | Source data word |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_empty | input | EMPTY_W | Unused symbols in the last word |
| in_chan | input | CH_W | Channel number |
| in_err | input | ERR_W | Error code |
| out_tvalid | output | 1 | Output word valid |
| out_tready | input | 1 | Sink can take a word |
| out_tdata | output | SYM_W*SYMS | Output data, first symbol in the low lane |
| out_tkeep | output | SYMS | Per-lane keep mask |
| out_tlast | output | 1 | Last word of a packet |
| out_tid | output | CH_W | Channel as stream identifier |
| out_tuser | output | ERR_W | Error code as user sideband |
| proto_err | output | 1 | Sticky flag for a start marker inside a packet |

## Verification
The hardest case to reach is a new word arriving while the output register is full and the sink is stalled. The bench gets there by dropping out_tready, loading one word, and then presenting a second word for several cycles; the second word must be refused while the first holds. Releasing out_tready in the same cycle then shows the drain-and-refill path: the second word is taken on that edge. The zero-length encoding and an ignored non-zero empty count on a middle word come from the vector table. The mid-packet start marker comes from two back-to-back start words.

// File: rtl/pkt_bridge_pkg.sv
package pkt_bridge_pkg;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_BODY = 1'b1
  } frame_state_e;

  // width of the unused-symbol count: one extra code when zero-length packets exist
  function automatic int unsigned calc_empty_w(input int unsigned syms, input bit zlp);
    int unsigned w;
    w = $clog2(syms + (zlp ? 1 : 0));
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/pbr_sym_reorder.sv
module pbr_sym_reorder #(
  parameter int unsigned SYM_W    = 8,
  parameter int unsigned SYMS     = 4,
  parameter bit          HI_FIRST = 1'b1,
  localparam int unsigned DATA_W  = SYM_W * SYMS
) (
  input  logic [DATA_W-1:0] src_word,
  output logic [DATA_W-1:0] lane_word
);

  for (genvar g = 0; g < SYMS; g++) begin : g_lane
    if (HI_FIRST) begin : g_rev
      assign lane_word[g*SYM_W +: SYM_W] = src_word[(SYMS-1-g)*SYM_W +: SYM_W];
    end else begin : g_keep
      assign lane_word[g*SYM_W +: SYM_W] = src_word[g*SYM_W +: SYM_W];
    end
  end

endmodule

// File: rtl/pbr_keep_gen.sv
module pbr_keep_gen #(
  parameter int unsigned SYMS    = 4,
  parameter int unsigned EMPTY_W = 3
) (
  input  logic               last_word,
  input  logic [EMPTY_W-1:0] unused_cnt,
  output logic [SYMS-1:0]    keep
);

  function automatic logic [SYMS-1:0] mask_for(input logic eop,
                                                input logic [EMPTY_W-1:0] emp);
    int unsigned e;
    int unsigned used;
    logic [SYMS-1:0] m;
    e    = 32'(emp);
    used = (e >= SYMS) ? 0 : SYMS - e;
    m    = '0;
    for (int i = 0; i < SYMS; i++) begin
      m[i] = (32'(i) < used);
    end
    return eop ? m : '1;
  endfunction

  assign keep = mask_for(last_word, unused_cnt);

endmodule

// File: rtl/pbr_frame_tracker.sv
module pbr_frame_tracker
  import pkt_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sop,
  input  logic eop,
  output logic err_flag
);

  frame_state_e state_q;
  logic         err_q;
  logic         mid_sop_hit;

  assign mid_sop_hit = take && sop && (state_q == FR_BODY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      err_q   <= 1'b0;
    end else begin
      if (take) state_q <= eop ? FR_IDLE : FR_BODY;
      if (mid_sop_hit) err_q <= 1'b1;
    end
  end

  assign err_flag = err_q;

  a_r9_sets: assert property (@(posedge clk) disable iff (!rst_n)
    mid_sop_hit |=> err_flag);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

endmodule

// File: rtl/pbr_out_stage.sv
module pbr_out_stage #(
  parameter int unsigned PAY_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_pay,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_pay,
  output logic             take
);

  logic             valid_q;
  logic [PAY_W-1:0] pay_q;

  assign up_ready = !valid_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pay_q   <= '0;
    end else begin
      if (up_ready) valid_q <= up_valid;
      if (take) pay_q <= up_pay;
    end
  end

  assign dn_valid = valid_q;
  assign dn_pay   = pay_q;

  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dn_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_pay)));

endmodule

// File: rtl/pkt_lane_bridge.sv
module pkt_lane_bridge
  import pkt_bridge_pkg::*;
#(
  parameter int unsigned SYM_W    = 8,
  parameter int unsigned SYMS     = 4,
  parameter int unsigned CH_W     = 2,
  parameter int unsigned ERR_W    = 2,
  parameter bit          HI_FIRST = 1'b1,
  parameter bit          ZLP_EN   = 1'b1,
  parameter int unsigned EMPTY_W  = calc_empty_w(SYMS, ZLP_EN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SYM_W*SYMS-1:0]  in_data,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [EMPTY_W-1:0]     in_empty,
  input  logic [CH_W-1:0]        in_chan,
  input  logic [ERR_W-1:0]       in_err,
  output logic                   out_tvalid,
  input  logic                   out_tready,
  output logic [SYM_W*SYMS-1:0]  out_tdata,
  output logic [SYMS-1:0]        out_tkeep,
  output logic                   out_tlast,
  output logic [CH_W-1:0]        out_tid,
  output logic [ERR_W-1:0]       out_tuser,
  output logic                   proto_err
);

  localparam int unsigned DATA_W = SYM_W * SYMS;
  localparam int unsigned PAY_W  = DATA_W + SYMS + 1 + CH_W + ERR_W;

  logic [DATA_W-1:0] lane_word;
  logic [SYMS-1:0]   keep_mask;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;
  logic              take;

  pbr_sym_reorder #(
    .SYM_W    (SYM_W),
    .SYMS     (SYMS),
    .HI_FIRST (HI_FIRST)
  ) u_reorder (
    .src_word  (in_data),
    .lane_word (lane_word)
  );

  pbr_keep_gen #(
    .SYMS    (SYMS),
    .EMPTY_W (EMPTY_W)
  ) u_keep (
    .last_word  (in_eop),
    .unused_cnt (in_empty),
    .keep       (keep_mask)
  );

  assign pay_in = {lane_word, keep_mask, in_eop, in_chan, in_err};

  pbr_out_stage #(
    .PAY_W (PAY_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_pay   (pay_in),
    .dn_valid (out_tvalid),
    .dn_ready (out_tready),
    .dn_pay   (pay_out),
    .take     (take)
  );

  assign {out_tdata, out_tkeep, out_tlast, out_tid, out_tuser} = pay_out;

  pbr_frame_tracker u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .sop      (in_sop),
    .eop      (in_eop),
    .err_flag (proto_err)
  );

  // R3: a word that is not the last of its packet leaves with every lane kept
  a_r3_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !out_tlast) |-> (&out_tkeep));

  // R5: an all-zero keep can only mark the last word of a zero-length packet
  a_r5_zlp_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && (out_tkeep == '0)) |-> out_tlast);

endmodule

// File: tb/pkt_lane_bridge_tb.sv
`timescale 1ns/1ps
module pkt_lane_bridge_tb;

  localparam int NV = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready, in_ready_lo;
  logic [31:0] in_data = '0;
  logic        in_sop = 1'b0, in_eop = 1'b0;
  logic [2:0]  in_empty = '0;
  logic [1:0]  in_chan = '0, in_err = '0;
  logic        out_tvalid, out_tvalid_lo;
  logic        out_tready = 1'b1;
  logic [31:0] out_tdata, out_tdata_lo;
  logic [3:0]  out_tkeep, out_tkeep_lo;
  logic        out_tlast, out_tlast_lo;
  logic [1:0]  out_tid, out_tid_lo, out_tuser, out_tuser_lo;
  logic        proto_err, proto_err_lo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  pkt_lane_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .in_chan(in_chan), .in_err(in_err), .out_tvalid(out_tvalid),
    .out_tready(out_tready), .out_tdata(out_tdata), .out_tkeep(out_tkeep),
    .out_tlast(out_tlast), .out_tid(out_tid), .out_tuser(out_tuser),
    .proto_err(proto_err)
  );

  pkt_lane_bridge #(.HI_FIRST(1'b0)) u_dut_lo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_lo),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .in_chan(in_chan), .in_err(in_err), .out_tvalid(out_tvalid_lo),
    .out_tready(out_tready), .out_tdata(out_tdata_lo), .out_tkeep(out_tkeep_lo),
    .out_tlast(out_tlast_lo), .out_tid(out_tid_lo), .out_tuser(out_tuser_lo),
    .proto_err(proto_err_lo)
  );

  // stimulus and expected results
  localparam logic [31:0] V_DATA [NV] = '{32'h11223344, 32'h55667788, 32'h99AABBCC,
    32'hDEADBEEF, 32'h01020304, 32'h00000000, 32'hA0B0C0D0, 32'hCAFEF00D, 32'h12345678};
  localparam logic        V_SOP  [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic        V_EOP  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [2:0]  V_EMP  [NV] = '{3'd0, 3'd3, 3'd1, 3'd0, 3'd3, 3'd4, 3'd2, 3'd0, 3'd0};
  localparam logic [1:0]  V_CH   [NV] = '{2'd1, 2'd1, 2'd0, 2'd2, 2'd3, 2'd0, 2'd1, 2'd0, 2'd0};
  localparam logic [1:0]  V_ERR  [NV] = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd3, 2'd0};
  localparam logic [31:0] X_DATA [NV] = '{32'h44332211, 32'h88776655, 32'hCCBBAA99,
    32'hEFBEADDE, 32'h04030201, 32'h00000000, 32'hD0C0B0A0, 32'h0DF0FECA, 32'h78563412};
  localparam logic [3:0]  X_KEEP [NV] = '{4'hF, 4'hF, 4'h7, 4'hF, 4'h1, 4'h0, 4'h3, 4'hF, 4'hF};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] d, input logic s, input logic e,
                       input logic [2:0] emp, input logic [1:0] ch, input logic [1:0] er);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    in_empty = emp; in_chan = ch; in_err = er;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 tvalid after reset", 64'(out_tvalid), 64'd0);
    chk("R10 in_ready after reset", 64'(in_ready), 64'd1);
    chk("R10 proto_err after reset", 64'(proto_err), 64'd0);

    // table walk, sink always ready
    for (int i = 0; i < NV; i++) begin
      drive(V_DATA[i], V_SOP[i], V_EOP[i], V_EMP[i], V_CH[i], V_ERR[i]);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7 tvalid after take", 64'(out_tvalid), 64'd1);
      chk("R1 reversed data", 64'(out_tdata), 64'(X_DATA[i]));
      chk("R2 low-first data unchanged", 64'(out_tdata_lo), 64'(V_DATA[i]));
      chk("R3/R4/R5 keep", 64'(out_tkeep), 64'(X_KEEP[i]));
      chk("R6 tlast", 64'(out_tlast), 64'(V_EOP[i]));
      chk("R6 tid", 64'(out_tid), 64'(V_CH[i]));
      chk("R6 tuser", 64'(out_tuser), 64'(V_ERR[i]));
      chk("R9 no error on legal framing", 64'(proto_err), 64'd0);
    end
    @(negedge clk);
    chk("R7 tvalid drops when idle", 64'(out_tvalid), 64'd0);

    // backpressure: full register, stalled sink, second word waiting
    out_tready = 1'b0;
    drive(32'h0A0B0C0D, 1'b1, 1'b1, 3'd0, 2'd2, 2'd1);
    @(negedge clk);
    drive(32'h5A6B7C8D, 1'b1, 1'b1, 3'd2, 2'd3, 2'd2);
    #1;
    chk("R7 ready low when full and stalled", 64'(in_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 data held", 64'(out_tdata), 64'h0D0C0B0A);
      chk("R8 tid held", 64'(out_tid), 64'd2);
      chk("R8 valid held", 64'(out_tvalid), 64'd1);
    end
    out_tready = 1'b1;
    #1;
    chk("R7 ready while draining", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 refill data", 64'(out_tdata), 64'h8D7C6B5A);
    chk("R4 refill keep", 64'(out_tkeep), 64'h3);
    chk("R6 refill tuser", 64'(out_tuser), 64'd2);

    // protocol error: start marker inside a packet
    drive(32'h01010101, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0);
    @(negedge clk);
    drive(32'h02020202, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 flag set on mid-packet start", 64'(proto_err), 64'd1);
    drive(32'h03030303, 1'b0, 1'b1, 3'd0, 2'd0, 2'd0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 flag sticky", 64'(proto_err), 64'd1);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 proto_err cleared by reset", 64'(proto_err), 64'd0);
    chk("R10 tvalid cleared by reset", 64'(out_tvalid), 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule